// File: doc/BRIEF.md
# Pipelined Double-Precision Floating-Point Adder/Subtractor

This block adds or subtracts two 64-bit binary floating-point operands in the standard double format. Bit 63 holds the sign, bits 62:52 the biased exponent and bits 51:0 the fraction. The datapath has five register stages. A new operation can enter on every clock cycle, and each result leaves exactly five cycles after its operands were taken in. A valid bit travels with each operation. There is no backpressure.

Inside, the operands are put in order by magnitude. The smaller significand is shifted right to line up with the larger one. The two significands are then added or subtracted in a 60-bit working field, which keeps the guard, round and sticky information. The sum is normalized and rounded to nearest with ties to even. Last, the exception rules are applied. Denormal operands take part in the arithmetic. Results that would fall below the normal range are flushed to zero and flagged. Results that go above the range are replaced by infinity and flagged. Any operand with an all-ones exponent (infinity or NaN) forces one fixed quiet-NaN pattern.

Top module: `fpadd_dp`

## Requirements
- R1: `out_valid` is low while reset is applied and after reset is released, until an operation passes through. An operation sampled with `in_valid` high on one rising edge shows up with `out_valid` high after the fifth rising edge from that edge. Operations may arrive on consecutive cycles and leave in order, one result for each input.
- R2: With `in_sub` high, the result is `in_a` plus `in_b` with the sign bit (bit 63) of `in_b` inverted. With `in_sub` low, the two operands are added.
- R3: For finite operands whose rounded result lies in the normal range, `out_result` is the exact sum rounded to nearest, with ties going to the even significand. The result uses sign bit 63, exponent bits 62:52 and fraction bits 51:0. Its sign comes from the operand of larger magnitude. Magnitude is compared on exponent first and fraction second, and `in_a` wins a tie.
- R4: An operand with a zero exponent field and a nonzero fraction is a denormal. It enters the sum with a hidden bit of 0 and an effective exponent of 1, so its exact value is kept.
- R5: A finite sum that is exactly zero gives a result with all 64 bits zero and all three flags low. This includes exact cancellation and the sum of two negative zeros.
- R6: If either operand has exponent field 0x7FF, the result has exponent 0x7FF, fraction 0x8000000000000 (only bit 51 set) and the sign of the larger-magnitude operand. `out_underflow` and `out_overflow` are low.
- R7: `out_invalid` is high exactly when one operand has exponent 0x7FF and the other is a denormal (zero exponent, nonzero fraction). Otherwise it is low.
- R8: If the rounded exponent of a finite, nonzero result is zero or negative, bits 62:0 are zero, bit 63 keeps the result sign, and `out_underflow` is high.
- R9: If the rounded exponent of a finite result is above 0x7FE, the result is exponent 0x7FF with fraction zero, its sign is kept, and `out_overflow` is high.
- R10: When rounding carries out of the significand, the fraction becomes zero and the exponent rises by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low reset; asserted asynchronously, released through a two-flop synchronizer |
| in_valid | input | 1 | An operation is presented on this cycle |
| in_sub | input | 1 | 1 selects subtraction (a - b), 0 selects addition |
| in_a | input | 64 | First operand |
| in_b | input | 64 | Second operand |
| out_valid | output | 1 | `out_result` and the flags are valid |
| out_result | output | 64 | Sum or difference |
| out_underflow | output | 1 | Result flushed to zero |
| out_overflow | output | 1 | Result replaced by infinity |
| out_invalid | output | 1 | An infinity or NaN met a denormal |

## Verification
The bench aims at points where the rounding can be off by one unit in the last place. These are exact ties on both an even and an odd significand, a rounding carry that turns an all-ones significand into the next power of two, and subtractions of nearly equal values with deep cancellation. A shifter that drops its sticky bit, or rounding that ignores the even rule, gives a result one step off. It also drives denormals into normal results, results just below the normal range, and sums past the largest finite value. A wrong effective exponent for denormals shows up as a result scaled by two. A wrong comparison on the flush or overflow threshold lets a bad value through. Infinity and NaN operands are paired with zeros, denormals and each other, which catches a NaN with the wrong sign or an invalid flag raised for a zero partner. A stream with random gaps checks that the valid bit stays aligned with its data.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
  // Double-precision field widths and the extended working field.
  localparam int unsigned EXP_W  = 11;
  localparam int unsigned FRAC_W = 52;
  localparam int unsigned EXT_W  = 60;
  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W;
  localparam int unsigned XE_W   = EXP_W + 2;
  localparam int unsigned NSTG   = 5;

  // Control bits that travel with an operation through every stage.
  typedef struct packed {
    logic sign;
    logic special;
    logic invalid;
  } fpadd_ctl_t;
endpackage

// File: rtl/fpadd_order.sv
// Unpacks both operands, applies the operation select, ranks them by
// magnitude and builds the extended significands for alignment.
module fpadd_order #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int EXT_W  = 60
) (
  input  logic [EXP_W+FRAC_W:0] op_a,
  input  logic [EXP_W+FRAC_W:0] op_b,
  input  logic                  sub,
  output logic                  sign_l,
  output logic                  eff_sub,
  output logic                  special,
  output logic                  invalid,
  output logic [EXP_W-1:0]      exp_l,
  output logic [EXP_W-1:0]      shift,
  output logic [EXT_W-1:0]      mant_l,
  output logic [EXT_W-1:0]      mant_s
);
  localparam int TOP   = EXP_W + FRAC_W;
  localparam int LOW_W = EXT_W - FRAC_W - 2;

  logic              sgn_a, sgn_b;
  logic [EXP_W-1:0]  ex_a, ex_b, xe_a, xe_b;
  logic [FRAC_W-1:0] fr_a, fr_b;
  logic [EXT_W-1:0]  sg_a, sg_b;
  logic              inf_a, inf_b, den_a, den_b, a_big;

  assign sgn_a = op_a[TOP];
  assign sgn_b = op_b[TOP] ^ sub;
  assign ex_a  = op_a[TOP-1:FRAC_W];
  assign ex_b  = op_b[TOP-1:FRAC_W];
  assign fr_a  = op_a[FRAC_W-1:0];
  assign fr_b  = op_b[FRAC_W-1:0];

  assign inf_a = &ex_a;
  assign inf_b = &ex_b;
  assign den_a = (ex_a == '0) && (fr_a != '0);
  assign den_b = (ex_b == '0) && (fr_b != '0);

  // Zero-exponent operands are weighted as exponent 1 with no hidden bit.
  assign xe_a = (ex_a == '0) ? EXP_W'(1) : ex_a;
  assign xe_b = (ex_b == '0) ? EXP_W'(1) : ex_b;
  assign sg_a = {1'b0, |ex_a, fr_a, {LOW_W{1'b0}}};
  assign sg_b = {1'b0, |ex_b, fr_b, {LOW_W{1'b0}}};

  assign a_big = op_a[TOP-1:0] >= op_b[TOP-1:0];

  always_comb begin
    if (a_big) begin
      sign_l = sgn_a;
      exp_l  = xe_a;
      shift  = xe_a - xe_b;
      mant_l = sg_a;
      mant_s = sg_b;
    end else begin
      sign_l = sgn_b;
      exp_l  = xe_b;
      shift  = xe_b - xe_a;
      mant_l = sg_b;
      mant_s = sg_a;
    end
  end

  assign eff_sub = sgn_a ^ sgn_b;
  assign special = inf_a | inf_b;
  assign invalid = (inf_a & den_b) | (inf_b & den_a);
endmodule

// File: rtl/fpadd_rshift.sv
// Logarithmic right shifter; every bit pushed past the LSB is folded
// into bit 0 so that rounding still sees it.
module fpadd_rshift #(
  parameter int W  = 60,
  parameter int AW = 11
) (
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] amt,
  output logic [W-1:0]  dout
);
  localparam int SW = $clog2(W);

  logic [W-1:0] stg [0:SW];
  logic         far;

  assign stg[0] = din;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int D = 1 << k;
    assign stg[k+1] = amt[k] ? {{D{1'b0}}, stg[k][W-1:D+1], |stg[k][D:0]}
                             : stg[k];
  end

  assign far  = |amt[AW-1:SW];
  assign dout = far ? {{(W-1){1'b0}}, |din} : stg[SW];
endmodule

// File: rtl/fpadd_lzc.sv
// Leading-zero counter; returns W when the input is all zero.
module fpadd_lzc #(
  parameter int W = 59
) (
  input  logic [W-1:0]             din,
  output logic [$clog2(W+1)-1:0]   cnt
);
  localparam int CW = $clog2(W + 1);

  always_comb begin
    cnt = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (din[i]) cnt = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fpadd_round.sv
// Round-to-nearest-even on a normalized significand, then the
// exception rules that pick the final word and flags.
module fpadd_round #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int EXT_W  = 60
) (
  input  logic [EXT_W-2:0]         norm,
  input  logic signed [EXP_W+1:0]  exp_in,
  input  logic                     sign,
  input  logic                     special,
  input  logic                     zero,
  output logic [EXP_W+FRAC_W:0]    result,
  output logic                     unf,
  output logic                     ovf
);
  localparam int LOW_W = EXT_W - FRAC_W - 2;
  localparam int XE_W  = EXP_W + 2;
  localparam logic signed [XE_W-1:0] EXP_MAX = XE_W'((1 << EXP_W) - 2);

  logic                     lsb, grd, rnd, stk, up;
  logic [FRAC_W+1:0]        sig;
  logic [FRAC_W-1:0]        frac_r;
  logic signed [XE_W-1:0]   exp_r;

  assign lsb = norm[LOW_W];
  assign grd = norm[LOW_W-1];
  assign rnd = norm[LOW_W-2];
  assign stk = |norm[LOW_W-3:0];
  assign up  = grd & (rnd | stk | lsb);

  assign sig    = {1'b0, norm[EXT_W-2:LOW_W]} + {{(FRAC_W+1){1'b0}}, up};
  assign frac_r = sig[FRAC_W+1] ? sig[FRAC_W:1] : sig[FRAC_W-1:0];
  assign exp_r  = exp_in + $signed({{(XE_W-1){1'b0}}, sig[FRAC_W+1]});

  always_comb begin
    unf = 1'b0;
    ovf = 1'b0;
    if (special) begin
      result = {sign, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    end else if (zero) begin
      result = '0;
    end else if (exp_r <= 0) begin
      result = {sign, {(EXP_W+FRAC_W){1'b0}}};
      unf    = 1'b1;
    end else if (exp_r > EXP_MAX) begin
      result = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      ovf    = 1'b1;
    end else begin
      result = {sign, exp_r[EXP_W-1:0], frac_r};
    end
  end
endmodule

// File: rtl/fpadd_dp.sv
module fpadd_dp
  import fpadd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sub,
  input  logic [WORD_W-1:0] in_a,
  input  logic [WORD_W-1:0] in_b,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_result,
  output logic              out_underflow,
  output logic              out_overflow,
  output logic              out_invalid
);
  localparam int LZ_W = $clog2(EXT_W);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  // Valid pipeline.
  logic [NSTG-1:0] vld_q, vld_d;
  assign vld_d = {vld_q[NSTG-2:0], in_valid};

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) vld_q <= '0;
    else          vld_q <= vld_d;
  end
  assign out_valid = vld_q[NSTG-1];

  // Stage 1: order operands.
  fpadd_ctl_t       s1_ctl_d, s1_ctl;
  logic             s1_esub_d, s1_esub;
  logic [EXP_W-1:0] s1_exp_d, s1_exp, s1_sh_d, s1_sh;
  logic [EXT_W-1:0] s1_ml_d, s1_ml, s1_ms_d, s1_ms;

  fpadd_order #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .EXT_W(EXT_W)) u_order (
    .op_a    (in_a),
    .op_b    (in_b),
    .sub     (in_sub),
    .sign_l  (s1_ctl_d.sign),
    .eff_sub (s1_esub_d),
    .special (s1_ctl_d.special),
    .invalid (s1_ctl_d.invalid),
    .exp_l   (s1_exp_d),
    .shift   (s1_sh_d),
    .mant_l  (s1_ml_d),
    .mant_s  (s1_ms_d)
  );

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_ctl  <= s1_ctl_d;
      s1_esub <= s1_esub_d;
      s1_exp  <= s1_exp_d;
      s1_sh   <= s1_sh_d;
      s1_ml   <= s1_ml_d;
      s1_ms   <= s1_ms_d;
    end
  end

  // Stage 2: align the smaller significand.
  fpadd_ctl_t       s2_ctl;
  logic             s2_esub;
  logic [EXP_W-1:0] s2_exp;
  logic [EXT_W-1:0] s2_ml, s2_ms_d, s2_ms;

  fpadd_rshift #(.W(EXT_W), .AW(EXP_W)) u_align (
    .din  (s1_ms),
    .amt  (s1_sh),
    .dout (s2_ms_d)
  );

  always_ff @(posedge clk) begin
    if (vld_q[0]) begin
      s2_ctl  <= s1_ctl;
      s2_esub <= s1_esub;
      s2_exp  <= s1_exp;
      s2_ml   <= s1_ml;
      s2_ms   <= s2_ms_d;
    end
  end

  AST_LARGER_FIRST: assert property (@(posedge clk) disable iff (!rst_q_n) (vld_q[1] && !s2_ctl.special) |-> (s2_ml >= s2_ms));  // R3

  // Stage 3: significand add or subtract.
  fpadd_ctl_t       s3_ctl;
  logic [EXP_W-1:0] s3_exp;
  logic [EXT_W-1:0] s3_sum_d, s3_sum;

  assign s3_sum_d = s2_esub ? (s2_ml - s2_ms) : (s2_ml + s2_ms);

  always_ff @(posedge clk) begin
    if (vld_q[1]) begin
      s3_ctl <= s2_ctl;
      s3_exp <= s2_exp;
      s3_sum <= s3_sum_d;
    end
  end

  // Stage 4: normalize.
  fpadd_ctl_t       s4_ctl;
  logic [LZ_W-1:0]  lz;
  logic [XE_W-1:0]  s4_exp_d, s4_exp, exp_ext;
  logic [EXT_W-2:0] s4_norm_d, s4_norm;
  logic             s4_zero_d, s4_zero;

  fpadd_lzc #(.W(EXT_W-1)) u_lzc (
    .din (s3_sum[EXT_W-2:0]),
    .cnt (lz)
  );

  assign exp_ext = {2'b00, s3_exp};

  always_comb begin
    s4_zero_d = (s3_sum == '0);
    if (s3_sum[EXT_W-1]) begin
      s4_norm_d = {s3_sum[EXT_W-1:2], s3_sum[1] | s3_sum[0]};
      s4_exp_d  = exp_ext + XE_W'(1);
    end else begin
      s4_norm_d = s3_sum[EXT_W-2:0] << lz;
      s4_exp_d  = exp_ext - XE_W'(lz);
    end
  end

  always_ff @(posedge clk) begin
    if (vld_q[2]) begin
      s4_ctl  <= s3_ctl;
      s4_exp  <= s4_exp_d;
      s4_norm <= s4_norm_d;
      s4_zero <= s4_zero_d;
    end
  end

  AST_LEAD_ONE: assert property (@(posedge clk) disable iff (!rst_q_n) (vld_q[3] && !s4_zero && !s4_ctl.special) |-> s4_norm[EXT_W-2]);  // R3

  // Stage 5: round and apply exception rules.
  logic [WORD_W-1:0] res_d;
  logic              unf_d, ovf_d;

  fpadd_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .EXT_W(EXT_W)) u_round (
    .norm    (s4_norm),
    .exp_in  ($signed(s4_exp)),
    .sign    (s4_ctl.sign),
    .special (s4_ctl.special),
    .zero    (s4_zero),
    .result  (res_d),
    .unf     (unf_d),
    .ovf     (ovf_d)
  );

  always_ff @(posedge clk) begin
    if (vld_q[3]) begin
      out_result    <= res_d;
      out_underflow <= unf_d;
      out_overflow  <= ovf_d;
      out_invalid   <= s4_ctl.invalid;
    end
  end

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_q_n) in_valid |-> ##5 out_valid);  // R1
  AST_SPECIAL_NAN: assert property (@(posedge clk) disable iff (!rst_q_n) (in_valid && ((&in_a[WORD_W-2:FRAC_W]) || (&in_b[WORD_W-2:FRAC_W]))) |-> ##5 (out_result[WORD_W-2:0] == {{EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}} && !out_underflow && !out_overflow));  // R6
  AST_INVALID_SHAPE: assert property (@(posedge clk) disable iff (!rst_q_n) (out_valid && out_invalid) |-> (&out_result[WORD_W-2:FRAC_W]));  // R7
  AST_UNDERFLOW_FLUSH: assert property (@(posedge clk) disable iff (!rst_q_n) (out_valid && out_underflow) |-> (out_result[WORD_W-2:0] == '0 && !out_overflow));  // R8
  AST_OVERFLOW_INF: assert property (@(posedge clk) disable iff (!rst_q_n) (out_valid && out_overflow) |-> (&out_result[WORD_W-2:FRAC_W] && out_result[FRAC_W-1:0] == '0));  // R9
endmodule

// File: tb/fpadd_dp_tb.sv
module fpadd_dp_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_RAND     = 3000;
  localparam int N_MAX      = 3200;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_sub = 1'b0;
  logic [63:0] in_a = '0;
  logic [63:0] in_b = '0;
  logic        out_valid;
  logic [63:0] out_result;
  logic        out_underflow, out_overflow, out_invalid;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpadd_dp u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_sub        (in_sub),
    .in_a          (in_a),
    .in_b          (in_b),
    .out_valid     (out_valid),
    .out_result    (out_result),
    .out_underflow (out_underflow),
    .out_overflow  (out_overflow),
    .out_invalid   (out_invalid)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int wr_idx   = 0;
  int rd_idx   = 0;
  bit done     = 1'b0;
  bit mon_on   = 1'b0;

  logic [66:0] exp_q [N_MAX];
  string       tag_q [N_MAX];

  task automatic check(string tag, string what, logic [66:0] act, logic [66:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  // Expected {invalid, overflow, underflow, result} from the requirements,
  // using host double arithmetic for the rounded sum.
  function automatic logic [66:0] model(logic [63:0] a, logic [63:0] b, logic sub);
    logic [63:0] bb, q, res;
    logic        spec, inv, unf, ovf, sl;
    real         ra, rb;
    bb   = {b[63] ^ sub, b[62:0]};
    spec = (a[62:52] == 11'h7ff) || (b[62:52] == 11'h7ff);
    inv  = ((a[62:52] == 11'h7ff) && (b[62:52] == 0) && (b[51:0] != 0)) ||
           ((b[62:52] == 11'h7ff) && (a[62:52] == 0) && (a[51:0] != 0));
    sl   = (a[62:0] >= b[62:0]) ? a[63] : bb[63];
    unf  = 1'b0;
    ovf  = 1'b0;
    if (spec) begin
      res = {sl, 11'h7ff, 52'h8000000000000};
    end else begin
      ra = $bitstoreal(a);
      rb = $bitstoreal(bb);
      q  = $realtobits(ra + rb);
      if (q[62:0] == 0) res = '0;
      else if (q[62:52] == 0) begin res = {q[63], 63'd0}; unf = 1'b1; end
      else if (q[62:52] == 11'h7ff) begin res = {q[63], 11'h7ff, 52'd0}; ovf = 1'b1; end
      else res = q;
    end
    return {inv, ovf, unf, res};
  endfunction

  function automatic string auto_tag(logic [66:0] e, logic [63:0] a, logic [63:0] b, logic sub);
    if (e[66]) return "R7";
    if (a[62:52] == 11'h7ff || b[62:52] == 11'h7ff) return "R6";
    if (e[65]) return "R9";
    if (e[64]) return "R8";
    if (e[63:0] == 0) return "R5";
    if ((a[62:52] == 0 && a[51:0] != 0) || (b[62:52] == 0 && b[51:0] != 0)) return "R4";
    if (sub) return "R2";
    return "R3";
  endfunction

  task automatic push(logic [63:0] a, logic [63:0] b, logic sub, string tag);
    exp_q[wr_idx] = model(a, b, sub);
    tag_q[wr_idx] = (tag == "") ? auto_tag(exp_q[wr_idx], a, b, sub) : tag;
    wr_idx++;
    in_a     = a;
    in_b     = b;
    in_sub   = sub;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [63:0] rnd_op(int kind, logic [10:0] near);
    logic [63:0] v;
    v = {$urandom, $urandom};
    case (kind)
      1: v[62:52] = near + 11'($urandom_range(0, 6)) - 11'd3;
      2: v[62:52] = 11'd0;
      3: v[62:52] = 11'd2040 + 11'($urandom_range(0, 6));
      4: v[62:52] = 11'd1 + 11'($urandom_range(0, 3));
      default: ;
    endcase
    return v;
  endfunction

  // Output monitor: compares each result with the next expected entry.
  always @(negedge clk) begin
    if (mon_on && out_valid) begin
      if (rd_idx >= wr_idx) begin
        check("R1", "result with no pending input", {3'b0, out_result}, 67'h0);
        n_fail++;
        $display("FAIL R1 extra output: actual valid expected none");
      end else begin
        check(tag_q[rd_idx], $sformatf("op %0d", rd_idx),
              {out_invalid, out_overflow, out_underflow, out_result}, exp_q[rd_idx]);
        rd_idx++;
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R1 watchdog: actual no completion expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] a, b;
    logic        s;
    int          cyc;
    void'($urandom(32'd7351));

    // Reset behaviour (R1).
    repeat (3) @(negedge clk);
    check("R1", "out_valid in reset", {66'd0, out_valid}, 67'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1", "out_valid after reset", {66'd0, out_valid}, 67'd0);

    // Latency of a single operation (R1).
    in_a = 64'h3FF0000000000000; in_b = 64'h3FF0000000000000; in_sub = 1'b0;
    in_valid = 1'b1;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
      in_valid = 1'b0;
    end while (!out_valid && cyc < 20);
    check("R1", "latency", 67'(cyc), 67'd5);
    check("R3", "1+1", {out_invalid, out_overflow, out_underflow, out_result}, {3'b000, 64'h4000000000000000});
    repeat (3) @(negedge clk);

    mon_on = 1'b1;
    // Directed corner cases, back to back.
    push(64'h3FF0000000000000, 64'h3FF0000000000000, 1'b1, "R2");
    push(64'h8000000000000000, 64'h8000000000000000, 1'b0, "R5");
    push(64'h4008000000000000, 64'hC008000000000000, 1'b0, "R5");
    push(64'h7FF0000000000000, 64'h3FF0000000000000, 1'b0, "R6");
    push(64'h3FF0000000000000, 64'h7FF0000000000000, 1'b1, "R6");
    push(64'hFFF0000000000000, 64'h7FF0000000000000, 1'b0, "R6");
    push(64'h7FF0000000000000, 64'h0000000000000001, 1'b0, "R7");
    push(64'h800FFFFFFFFFFFFF, 64'h7FF8000000000000, 1'b0, "R7");
    push(64'h7FF0000000000000, 64'h0000000000000000, 1'b0, "R7");
    push(64'h7FEFFFFFFFFFFFFF, 64'h7FEFFFFFFFFFFFFF, 1'b0, "R9");
    push(64'hFFEFFFFFFFFFFFFF, 64'h7CA0000000000000, 1'b1, "R9");
    push(64'h0010000000000000, 64'h0000000000000001, 1'b1, "R8");
    push(64'h8010000000000000, 64'h0000000000000001, 1'b0, "R8");
    push(64'h0000000000000003, 64'h0008000000000000, 1'b0, "R8");
    push(64'h0010000000000000, 64'h0000000000000001, 1'b0, "R4");
    push(64'h000FFFFFFFFFFFFF, 64'h0000000000000001, 1'b0, "R4");
    push(64'h3FF0000000000000, 64'h3CA0000000000000, 1'b0, "R3");
    push(64'h3FF0000000000001, 64'h3CA0000000000000, 1'b0, "R3");
    push(64'h3FFFFFFFFFFFFFFF, 64'h3CA0000000000000, 1'b0, "R10");
    push(64'h7FDFFFFFFFFFFFFF, 64'h7C9FFFFFFFFFFFFF, 1'b0, "R10");
    push(64'h3FF0000000000000, 64'h0010000000000000, 1'b0, "R3");
    push(64'h3CA0000000000000, 64'hBFF0000000000000, 1'b0, "R3");
    push(64'h3FF0000000000000, 64'h3FEFFFFFFFFFFFFF, 1'b1, "R2");

    // Constrained random stream with occasional idle cycles.
    for (int i = 0; i < N_RAND; i++) begin
      int mode;
      mode = $urandom_range(0, 5);
      case (mode)
        0: begin a = rnd_op(0, 0); b = rnd_op(0, 0); end
        1: begin a = rnd_op(1, 11'($urandom_range(4, 2042))); b = rnd_op(1, a[62:52]); end
        2: begin
             a = rnd_op(1, 11'($urandom_range(4, 2042)));
             b = a ^ ({$urandom, $urandom} & ((64'd1 << $urandom_range(0, 52)) - 64'd1));
             b[63] = $urandom_range(0, 1);
           end
        3: begin a = rnd_op(2, 0); b = rnd_op($urandom_range(0, 1) ? 2 : 4, 0); end
        4: begin a = rnd_op(3, 0); b = rnd_op(3, 0); end
        default: begin a = rnd_op(1, 11'($urandom_range(100, 1900)));
                       b = rnd_op(1, a[62:52] - 11'($urandom_range(50, 99))); end
      endcase
      s = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 9) == 0) @(negedge clk);
      push(a, b, s, "");
    end

    cyc = 0;
    while (rd_idx < wr_idx && cyc < 50) begin
      @(negedge clk);
      cyc++;
    end
    check("R1", "outputs received", 67'(rd_idx), 67'(wr_idx));
    repeat (4) @(negedge clk);
    check("R1", "no trailing valid", {66'd0, out_valid}, 67'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule